// File: doc/BRIEF.md
# Multiplexed Digit Scanner

This block puts a small set of stored BCD digits onto one shared 4-bit output bus, one digit at a time. Each digit has its own active-low select line. The select lines tell an external display which digit position the bus is currently feeding. A scan tick moves the scanner to the next digit. The tick is a single-cycle enable in the system clock domain, and it stands in for a slow scan oscillator or an external scan clock.

The digits arrive packed into one input vector, least significant digit in the lowest bits. The bus and the active select line both come from the same position register. The bus is a combinational selection from that register and the current digit inputs, so a new value on a digit input shows up on the bus in the same cycle while that digit is selected.

Master reset is asynchronous and active high. While it is high, the scanner is parked on the first digit, every select line is held high (inactive) and scan ticks have no effect. On the first clock edge after reset is released, the first digit's select line goes low. From then on, each tick advances the scan. There is no data handshake: the outputs are a free-running display drive.

Top module: `digit_scan_mux`

## Requirements
- R1: While `rst` is high, every bit of `dsel_n` is 1.
- R2: While `rst` is high, `bcd_out` equals the first digit, `digits_in[3:0]`.
- R3: A `scan_tick` that is high while `rst` is high has no effect: after release, scanning still starts on the first digit.
- R4: On the first clock edge with `rst` low, `dsel_n` becomes 3'b110 (bit 0, the least significant digit, active low) and `bcd_out` shows `digits_in[3:0]`. No tick is taken on that edge.
- R5: Once running, a clock edge with `scan_tick` high moves the low select bit 0 to 1, 1 to 2, and 2 back to 0.
- R6: Once running, a clock edge with `scan_tick` low leaves `dsel_n` unchanged.
- R7: At most one bit of `dsel_n` is low in any cycle.
- R8: Whenever bit k of `dsel_n` is low, `bcd_out` equals `digits_in[4k+3:4k]` in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge |
| rst | input | 1 | Master reset, asynchronous, active high |
| scan_tick | input | 1 | One-cycle enable that advances the scan |
| digits_in | input | 12 | Packed BCD digits, least significant digit in bits 3:0 |
| bcd_out | output | 4 | Shared BCD bus, active high |
| dsel_n | output | 3 | Digit select lines, active low, bit 0 is the least significant digit |

## Verification
The bound checker watches every cycle for the following:
- the reset drive of the select lines and the bus;
- the single-active-select rule;
- the bus-to-select data match;
- rotation on a tick, hold without a tick, and the start on the first digit after release.

The requirement that ticks during reset are ignored is shown only by the bench's scenarios. Those scenarios hold the tick high through a reset and reassert reset in the middle of a scan. The bench also changes the digit values every cycle, which shows that the bus follows the selected digit with no lag.

// File: rtl/dscan_pkg.sv
package dscan_pkg;

  // Width of a position index able to address n digits.
  function automatic int unsigned pos_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/dscan_pos.sv
module dscan_pos #(
  parameter int unsigned N  = 3,
  parameter int unsigned IW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  output logic [IW-1:0] pos_o,
  output logic          run_o
);

  localparam logic [IW-1:0] LAST = IW'(N - 1);

  logic [IW-1:0] pos_q;
  logic          run_q;

  // Reset parks on digit 0 and stops scanning; the first edge after
  // release only arms the scanner, later ticks rotate the position.
  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      pos_q <= '0;
      run_q <= 1'b0;
    end else if (!run_q) begin
      run_q <= 1'b1;
    end else if (tick) begin
      pos_q <= (pos_q == LAST) ? '0 : pos_q + IW'(1);
    end
  end

  assign pos_o = pos_q;
  assign run_o = run_q;

endmodule

// File: rtl/dscan_sel.sv
module dscan_sel #(
  parameter int unsigned N  = 3,
  parameter int unsigned IW = 2
) (
  input  logic [IW-1:0] pos_i,
  input  logic          run_i,
  output logic [N-1:0]  sel_n_o
);

  for (genvar g = 0; g < N; g++) begin : g_line
    assign sel_n_o[g] = !(run_i && (pos_i == IW'(g)));
  end

endmodule

// File: rtl/dscan_mux.sv
module dscan_mux #(
  parameter int unsigned N  = 3,
  parameter int unsigned W  = 4,
  parameter int unsigned IW = 2
) (
  input  logic [N*W-1:0] digits_i,
  input  logic [IW-1:0]  pos_i,
  output logic [W-1:0]   bus_o
);

  logic [W-1:0] slot [N];

  for (genvar g = 0; g < N; g++) begin : g_slot
    assign slot[g] = digits_i[g*W +: W];
  end

  always_comb begin
    bus_o = '0;
    for (int i = 0; i < N; i++) begin
      if (pos_i == IW'(i)) bus_o = slot[i];
    end
  end

endmodule

// File: rtl/digit_scan_mux.sv
module digit_scan_mux #(
  parameter int unsigned N = 3,
  parameter int unsigned W = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           scan_tick,
  input  logic [N*W-1:0] digits_in,
  output logic [W-1:0]   bcd_out,
  output logic [N-1:0]   dsel_n
);

  localparam int unsigned IW = dscan_pkg::pos_width(N);

  logic [IW-1:0] pos;
  logic          run;

  dscan_pos #(.N(N), .IW(IW)) u_pos (
    .clk   (clk),
    .rst   (rst),
    .tick  (scan_tick),
    .pos_o (pos),
    .run_o (run)
  );

  dscan_sel #(.N(N), .IW(IW)) u_sel (
    .pos_i   (pos),
    .run_i   (run),
    .sel_n_o (dsel_n)
  );

  dscan_mux #(.N(N), .W(W), .IW(IW)) u_mux (
    .digits_i (digits_in),
    .pos_i    (pos),
    .bus_o    (bcd_out)
  );

endmodule

// File: rtl/dscan_chk.sv
module dscan_chk #(
  parameter int unsigned N = 3,
  parameter int unsigned W = 4
) (
  input logic           clk,
  input logic           rst,
  input logic           scan_tick,
  input logic [N*W-1:0] digits_in,
  input logic [W-1:0]   bcd_out,
  input logic [N-1:0]   dsel_n
);

  logic [N-1:0] act;
  logic [N-1:0] act_rot;
  logic [W-1:0] want_bus;

  assign act     = ~dsel_n;
  assign act_rot = {act[N-2:0], act[N-1]};

  always_comb begin
    want_bus = '0;
    for (int i = 0; i < N; i++) begin
      if (act[i]) want_bus = digits_in[i*W +: W];
    end
  end

  p_idle_sel_r1: assert property (@(posedge clk) rst |-> (&dsel_n));

  p_park_bus_r2: assert property (@(posedge clk) rst |-> (bcd_out == digits_in[W-1:0]));

  p_first_digit_r4: assert property (@(posedge clk) disable iff (rst)
    (&dsel_n) |=> (dsel_n == ~{{(N-1){1'b0}}, 1'b1}));

  p_rotate_r5: assert property (@(posedge clk) disable iff (rst)
    ((act != '0) && scan_tick) |=> (act == $past(act_rot)));

  p_hold_r6: assert property (@(posedge clk) disable iff (rst)
    ((act != '0) && !scan_tick) |=> $stable(dsel_n));

  p_one_sel_r7: assert property (@(posedge clk) disable iff (rst)
    $countones(act) <= 1);

  p_bus_match_r8: assert property (@(posedge clk) disable iff (rst)
    (act != '0) |-> (bcd_out == want_bus));

endmodule

bind digit_scan_mux dscan_chk #(.N(N), .W(W)) u_dscan_chk (
  .clk       (clk),
  .rst       (rst),
  .scan_tick (scan_tick),
  .digits_in (digits_in),
  .bcd_out   (bcd_out),
  .dsel_n    (dsel_n)
);

// File: tb/test_digit_scan_mux.sv
`timescale 1ns/1ps
module test_digit_scan_mux;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        scan_tick = 1'b0;
  logic [11:0] digits_in = 12'h321;
  logic [3:0]  bcd_out;
  logic [2:0]  dsel_n;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // Reference model state
  int  m_pos = 0;
  bit  m_run = 0;
  bit  m_started = 0;
  bit  m_ticked = 0;

  always #10 clk = ~clk;

  digit_scan_mux i_digit_scan_mux (
    .clk       (clk),
    .rst       (rst),
    .scan_tick (scan_tick),
    .digits_in (digits_in),
    .bcd_out   (bcd_out),
    .dsel_n    (dsel_n)
  );

  always @(posedge clk) begin
    m_started = 0;
    m_ticked  = 0;
    if (rst) begin
      m_pos = 0;
      m_run = 0;
    end else if (!m_run) begin
      m_run = 1;
      m_started = 1;
    end else if (scan_tick) begin
      m_pos = (m_pos + 1) % 3;
      m_ticked = 1;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic compare();
    int exp_sel;
    int exp_bus;
    string tag;
    exp_sel = (rst || !m_run) ? 7 : (7 & ~(1 << m_pos));
    exp_bus = (digits_in >> (4 * m_pos)) & 15;
    if (rst) begin
      check("R1", dsel_n, exp_sel);
      check("R2", bcd_out, exp_bus);
    end else begin
      if (m_started)     tag = "R4";
      else if (m_ticked) tag = "R5";
      else               tag = "R6";
      check(tag, dsel_n, exp_sel);
      check("R8", bcd_out, exp_bus);
    end
    check("R7", ($countones(~dsel_n) <= 1) ? 1 : 0, 1);
  endtask

  // one cycle: compare at falling edge, then drive next inputs
  task automatic step(input bit r, input bit t, input logic [11:0] d);
    @(negedge clk);
    compare();
    rst = r;
    scan_tick = t;
    digits_in = d;
    if (r) begin
      m_pos = 0;
      m_run = 0;
    end
  endtask

  function automatic logic [11:0] rnd_digits();
    logic [11:0] v;
    for (int k = 0; k < 3; k++) v[k*4 +: 4] = 4'($urandom_range(0, 9));
    return v;
  endfunction

  initial begin
    // reset held, ticks pulsing (ticks must be ignored)
    for (int i = 0; i < 6; i++) step(1, i[0], 12'h987);
    step(0, 1, 12'h987);
    // first edge after release: digit 0 must be selected (R3)
    @(negedge clk);
    check("R3", dsel_n, 3'b110);
    check("R3", bcd_out, 4'h7);
    // tick every cycle
    for (int i = 0; i < 12; i++) step(0, 1, 12'h456);
    // no ticks, changing digits
    for (int i = 0; i < 10; i++) step(0, 0, rnd_digits());
    // sparse random ticks and random digits
    for (int i = 0; i < 150; i++) step(0, ($urandom_range(0, 3) == 0), rnd_digits());
    // reset mid scan with tick high, then release with tick held
    for (int i = 0; i < 4; i++) step(1, 1, rnd_digits());
    for (int i = 0; i < 40; i++) step(0, 1, rnd_digits());
    for (int i = 0; i < 60; i++) step(0, $urandom_range(0, 1), rnd_digits());
    @(negedge clk);
    compare();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 20000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual running expected done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule